// File: doc/BRIEF.md
# Oscillator-Jitter Random Bit Extractor

This block turns two free-running oscillators of nearly equal frequency into a stream of debiased random bits. The sampling oscillator registers the level of the other oscillator, so each raw bit depends on the phase jitter between the two. The sampled signal passes through a second register before anything uses it, which gives a metastable first flop time to settle. A post-processor then combines the raw bits two at a time. It can either XOR each pair, or apply a von Neumann corrector that keeps only unequal pairs. Each result crosses into the system clock domain over a toggle handshake and appears as a bit with a one-cycle valid pulse.

A health monitor also watches the sampled signal, called S0. It measures how many sampling-oscillator cycles each S0 period lasts. When the measured lengths stop changing, the source has become deterministic, and the monitor raises an alarm that stays set until reset. An optional dual-edge mode also samples on the falling edge of the sampling oscillator, which doubles the raw bit rate.

Top module: `jitter_bit_extractor`

## Requirements
- R1: `data_osc_i` is registered on each rising edge of `samp_osc_i`, then goes through one more register before use. The raw stream is these samples in order, starting at the first rising edge after reset release.
- R2: With `vn_mode_i`=0 (XOR), raw bits are grouped into non-overlapping pairs (samples 0 and 1, then 2 and 3, and so on). Each pair gives exactly one output bit, equal to the XOR of the two bits.
- R3: With `vn_mode_i`=1 (von Neumann), each output bit equals the first bit of its pair. A pair 0,1 therefore outputs 0, a pair 1,0 outputs 1, and pairs 0,0 and 1,1 output nothing.
- R4: With `dual_edge_i`=1, `data_osc_i` is also sampled on each falling edge of `samp_osc_i`. Every rising-edge sample forms a pair with the falling-edge sample just before it, the falling sample first, so each sampling period gives one pair.
- R5: Both mode inputs are captured once, at the first rising edge of `samp_osc_i` after reset. Later changes to them have no effect until the next reset.
- R6: Each output bit appears on `rnd_bit_o` together with a one-cycle pulse on `rnd_valid_o` in the `clk_i` domain. Bits arrive in the order they were produced, and `rnd_bit_o` holds its value between pulses.
- R7: The length of an S0 period is the count of sampling cycles from one S0 rising edge to the next. The counter stops at 255 instead of wrapping. While it is stopped there, every sampling cycle counts as a measurement of 255, and each such measurement counts as a repeat. This lets a stuck S0 also raise the alarm.
- R8: `alarm_o` rises after ALARM_RUN (default 64) measured lengths in a row that each repeat the one before. It stays low while the lengths keep varying.
- R9: `alarm_o` stays set until reset. Reset clears `alarm_o`, `rnd_valid_o` and `rnd_bit_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock for the output side |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| samp_osc_i | input | 1 | Sampling oscillator |
| data_osc_i | input | 1 | Sampled (jittery) oscillator |
| vn_mode_i | input | 1 | 1 selects the von Neumann corrector, 0 selects pairwise XOR |
| dual_edge_i | input | 1 | 1 also samples on falling edges of `samp_osc_i` |
| rnd_bit_o | output | 1 | Output random bit |
| rnd_valid_o | output | 1 | One-cycle pulse marking a new `rnd_bit_o` |
| alarm_o | output | 1 | Sticky alarm: the source has become deterministic |

## Verification
The bench aims first at pair alignment after reset. A design that starts pairing one sample late, or lets pairs overlap, produces a shifted XOR stream or keeps the wrong von Neumann pairs. It also checks that the falling-edge sample comes first in dual-edge mode, because a swapped order flips every von Neumann output. The mode inputs are changed in the middle of a run to catch a design that reads them live, which would cause an abrupt change in output rate and values. Finally, an exactly periodic source and a stuck-low source must each raise the alarm, while a jittered one must not. A counter that wraps, or a run counter that never clears, would break one of these three cases.

// File: rtl/jbx_pkg.sv
package jbx_pkg;

  typedef struct packed {
    logic emit;
    logic value;
  } pp_out_t;

  // Post-processing of one raw pair (a first, b second).
  function automatic pp_out_t pp_debias(input logic vn, input logic a, input logic b);
    pp_out_t r;
    if (vn) begin
      r.emit  = a ^ b;
      r.value = a;
    end else begin
      r.emit  = 1'b1;
      r.value = a ^ b;
    end
    return r;
  endfunction

endpackage

// File: rtl/jbx_sampler.sv
module jbx_sampler (
  input  logic samp_clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic dual_req,
  input  logic vn_req,
  output logic dual_q,
  output logic vn_q,
  output logic s0,
  output logic s0_vld,
  output logic pair_vld,
  output logic pair_a,
  output logic pair_b
);

  logic fs, fv;
  logic r1, r2, f1, f2, v1, v2, pv1, pv2;
  logic cfg_done, phase, hold;

  // falling-edge capture for dual-edge mode
  always_ff @(negedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      fs <= 1'b0;
      fv <= 1'b0;
    end else begin
      fs <= data_in;
      fv <= 1'b1;
    end
  end

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      dual_q   <= 1'b0;
      vn_q     <= 1'b0;
      r1 <= 1'b0; r2 <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
      v1 <= 1'b0; v2 <= 1'b0; pv1 <= 1'b0; pv2 <= 1'b0;
      phase <= 1'b0;
      hold  <= 1'b0;
    end else begin
      if (!cfg_done) begin
        cfg_done <= 1'b1;
        dual_q   <= dual_req;
        vn_q     <= vn_req;
      end
      // capture stage
      r1  <= data_in;
      f1  <= fs;
      v1  <= 1'b1;
      pv1 <= fv;
      // settling stage
      r2  <= r1;
      f2  <= f1;
      v2  <= v1;
      pv2 <= pv1;
      if (v2) begin
        phase <= ~phase;
        hold  <= r2;
      end
    end
  end

  assign s0       = r2;
  assign s0_vld   = v2;
  assign pair_vld = v2 && (dual_q ? pv2 : phase);
  assign pair_a   = dual_q ? f2 : hold;
  assign pair_b   = r2;

  // R5: modes frozen once captured
  p_cfg_frozen_r5: assert property (@(posedge samp_clk) disable iff (!rst_n)
    cfg_done |=> ($stable(dual_q) && $stable(vn_q)));

  // R2: single-edge pairs never come back to back
  p_no_overlap_r2: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (pair_vld && !dual_q) |=> !pair_vld);

endmodule

// File: rtl/jbx_cycle_mon.sv
module jbx_cycle_mon #(
  parameter int CNT_W     = 8,
  parameter int ALARM_RUN = 64
) (
  input  logic samp_clk,
  input  logic rst_n,
  input  logic s0,
  input  logic s0_vld,
  output logic alarm
);

  localparam int RUN_W = $clog2(ALARM_RUN + 1);
  localparam logic [CNT_W-1:0] LEN_MAX = '1;

  logic [CNT_W-1:0] cnt, prev_len, meas_len;
  logic [RUN_W-1:0] run;
  logic s0_prev, seen_edge, prev_vld;
  logic s0_rise, meas_evt, meas_same;

  function automatic logic len_repeats(input logic [CNT_W-1:0] len,
                                       input logic [CNT_W-1:0] prev,
                                       input logic pv);
    return (len == LEN_MAX) || (pv && (len == prev));
  endfunction

  always_comb begin
    s0_rise   = s0_vld && s0 && !s0_prev;
    meas_len  = s0_rise ? cnt : LEN_MAX;
    meas_evt  = s0_vld && (s0_rise ? (seen_edge || cnt == LEN_MAX) : (cnt == LEN_MAX));
    meas_same = len_repeats(meas_len, prev_len, prev_vld);
  end

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_len  <= '0;
      prev_vld  <= 1'b0;
      s0_prev   <= 1'b0;
      seen_edge <= 1'b0;
      run       <= '0;
      alarm     <= 1'b0;
    end else begin
      if (s0_vld) begin
        s0_prev <= s0;
        if (s0_rise) begin
          cnt       <= CNT_W'(1);
          seen_edge <= 1'b1;
        end else if (cnt != LEN_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
      if (meas_evt) begin
        prev_len <= meas_len;
        prev_vld <= 1'b1;
        if (meas_same) begin
          if (run != RUN_W'(ALARM_RUN)) run <= run + 1'b1;
          if (run >= RUN_W'(ALARM_RUN - 1)) alarm <= 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end

  // R7: the length counter holds at its ceiling
  p_len_no_wrap_r7: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (s0_vld && cnt == LEN_MAX && !s0_rise) |=> (cnt == LEN_MAX));

  // R8: alarm only rises on a repeating measurement
  p_alarm_cause_r8: assert property (@(posedge samp_clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(meas_evt && meas_same));

  // R9: alarm is sticky
  p_alarm_sticky_r9: assert property (@(posedge samp_clk) disable iff (!rst_n)
    alarm |=> alarm);

endmodule

// File: rtl/jbx_debias.sv
module jbx_debias
  import jbx_pkg::*;
(
  input  logic samp_clk,
  input  logic rst_n,
  input  logic vn_q,
  input  logic pair_vld,
  input  logic pair_a,
  input  logic pair_b,
  output logic out_bit,
  output logic out_tog
);

  pp_out_t res;
  logic emit;

  assign res  = pp_debias(vn_q, pair_a, pair_b);
  assign emit = pair_vld && res.emit;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit <= 1'b0;
      out_tog <= 1'b0;
    end else if (emit) begin
      out_bit <= res.value;
      out_tog <= ~out_tog;
    end
  end

  // R2: XOR mode emits for every pair
  p_xor_emits_r2: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (pair_vld && !vn_q) |=> (out_tog != $past(out_tog)));

  // R3: equal pairs are dropped in von Neumann mode
  p_vn_drop_r3: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (pair_vld && vn_q && (pair_a == pair_b)) |=> $stable(out_tog));

  // R3: unequal pairs give their first bit
  p_vn_value_r3: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (pair_vld && vn_q && (pair_a != pair_b)) |=> (out_bit == $past(pair_a)));

endmodule

// File: rtl/jbx_cdc.sv
module jbx_cdc #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  input  logic bit_in,
  input  logic alarm_in,
  output logic rnd_valid,
  output logic rnd_bit,
  output logic alarm
);

  logic [SYNC_STAGES:0]   tsync;
  logic [SYNC_STAGES-1:0] async_q;
  logic                   tog_edge;

  assign tog_edge = tsync[SYNC_STAGES] ^ tsync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsync     <= '0;
      async_q   <= '0;
      rnd_valid <= 1'b0;
      rnd_bit   <= 1'b0;
    end else begin
      tsync     <= {tsync[SYNC_STAGES-1:0], tog_in};
      async_q   <= {async_q[SYNC_STAGES-2:0], alarm_in};
      rnd_valid <= tog_edge;
      if (tog_edge) rnd_bit <= bit_in;
    end
  end

  assign alarm = async_q[SYNC_STAGES-1];

  // R6: valid is a single-cycle pulse
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |=> !rnd_valid);

  // R6: data holds between pulses
  p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_edge |=> $stable(rnd_bit));

endmodule

// File: rtl/jitter_bit_extractor.sv
module jitter_bit_extractor #(
  parameter int CNT_W       = 8,
  parameter int ALARM_RUN   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic samp_osc_i,
  input  logic data_osc_i,
  input  logic vn_mode_i,
  input  logic dual_edge_i,
  output logic rnd_bit_o,
  output logic rnd_valid_o,
  output logic alarm_o
);

  logic dual_q, vn_q, s0, s0_vld;
  logic pair_vld, pair_a, pair_b;
  logic out_bit, out_tog, src_alarm;

  jbx_sampler u_sampler (
    .samp_clk (samp_osc_i),
    .rst_n    (rst_ni),
    .data_in  (data_osc_i),
    .dual_req (dual_edge_i),
    .vn_req   (vn_mode_i),
    .dual_q   (dual_q),
    .vn_q     (vn_q),
    .s0       (s0),
    .s0_vld   (s0_vld),
    .pair_vld (pair_vld),
    .pair_a   (pair_a),
    .pair_b   (pair_b)
  );

  jbx_cycle_mon #(.CNT_W(CNT_W), .ALARM_RUN(ALARM_RUN)) u_mon (
    .samp_clk (samp_osc_i),
    .rst_n    (rst_ni),
    .s0       (s0),
    .s0_vld   (s0_vld),
    .alarm    (src_alarm)
  );

  jbx_debias u_debias (
    .samp_clk (samp_osc_i),
    .rst_n    (rst_ni),
    .vn_q     (vn_q),
    .pair_vld (pair_vld),
    .pair_a   (pair_a),
    .pair_b   (pair_b),
    .out_bit  (out_bit),
    .out_tog  (out_tog)
  );

  jbx_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .tog_in    (out_tog),
    .bit_in    (out_bit),
    .alarm_in  (src_alarm),
    .rnd_valid (rnd_valid_o),
    .rnd_bit   (rnd_bit_o),
    .alarm     (alarm_o)
  );

endmodule

// File: tb/jitter_bit_extractor_tb.sv
`timescale 1ns/1ps
module jitter_bit_extractor_tb;

  logic clk = 1'b0, rst_n = 1'b1, samp_osc = 1'b0, data_osc = 1'b0;
  logic vn_in = 1'b0, dual_in = 1'b0;
  logic rnd_bit, rnd_valid, alarm;

  int checks = 0, fails = 0, popped = 0;
  int a_mode = 0;
  bit exp_q[$];
  bit rec_on = 1'b0, m_vn = 1'b0, m_dual = 1'b0;
  bit have_first = 1'b0, first_v = 1'b0, fall_ok = 1'b0, fall_v = 1'b0;
  string cur_req = "R6";

  jitter_bit_extractor u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .samp_osc_i  (samp_osc),
    .data_osc_i  (data_osc),
    .vn_mode_i   (vn_in),
    .dual_edge_i (dual_in),
    .rnd_bit_o   (rnd_bit),
    .rnd_valid_o (rnd_valid),
    .alarm_o     (alarm)
  );

  always #10 clk = ~clk;            // 50 MHz
  always #100 samp_osc = ~samp_osc; // edges on multiples of 100 ns

  // data oscillator: toggles only at 5 mod 10 ns, never on a sampling edge
  initial begin
    #5;
    forever begin
      case (a_mode)
        0: begin #(10 * $urandom_range(6, 14)); data_osc = ~data_osc; end
        1: begin #400; data_osc = ~data_osc; end
        default: begin #10; data_osc = 1'b0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference post-processor (R2, R3)
  function automatic void push_pair(input bit a, input bit b);
    if (m_vn) begin
      if (a != b) exp_q.push_back(a);
    end else begin
      exp_q.push_back(a ^ b);
    end
  endfunction

  // driver side: record raw samples (R1, R4)
  always @(posedge samp_osc) begin
    if (rec_on) begin
      if (m_dual) begin
        if (fall_ok) push_pair(fall_v, data_osc);
      end else if (have_first) begin
        push_pair(first_v, data_osc);
        have_first = 1'b0;
      end else begin
        first_v    = data_osc;
        have_first = 1'b1;
      end
    end
  end

  always @(negedge samp_osc) begin
    if (rec_on) begin
      fall_v  = data_osc;
      fall_ok = 1'b1;
    end
  end

  // monitor: compare each output with the scoreboard (R6)
  always @(negedge clk) begin
    if (rst_n && rnd_valid) begin
      bit e;
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s: actual=%0d expected=none", cur_req, rnd_bit);
      end else begin
        e = exp_q.pop_front();
        check(rnd_bit == e, cur_req, rnd_bit, e);
        popped++;
      end
    end
  end

  task automatic do_reset(input bit vn, input bit dual);
    @(posedge samp_osc); #57;
    rst_n = 1'b0;
    rec_on = 1'b0;
    exp_q.delete();
    have_first = 1'b0;
    fall_ok = 1'b0;
    m_vn = vn; m_dual = dual;
    vn_in = vn; dual_in = dual;
    #400;
    // R9: reset state
    check(alarm == 1'b0, "R9 reset alarm", alarm, 0);
    check(rnd_valid == 1'b0, "R9 reset valid", rnd_valid, 0);
    check(rnd_bit == 1'b0, "R9 reset bit", rnd_bit, 0);
    @(posedge samp_osc); #57;
    popped = 0;
    rst_n = 1'b1;
    rec_on = 1'b1;
  endtask

  task automatic wait_outputs(input int n);
    while (popped < n) @(negedge clk);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    #50;
    check(alarm == 1'b0, "R9 power-up alarm", alarm, 0);
    check(rnd_valid == 1'b0, "R9 power-up valid", rnd_valid, 0);

    // XOR, single edge, jittered; mode inputs flipped mid-run (R1 R2 R5)
    a_mode = 0;
    cur_req = "R2 xor single";
    do_reset(1'b0, 1'b0);
    wait_outputs(20);
    cur_req = "R5 modes changed after reset";
    vn_in = 1'b1; dual_in = 1'b1;
    wait_outputs(45);
    check(alarm == 1'b0, "R8 jittered xor", alarm, 0);

    // von Neumann, single edge (R3)
    cur_req = "R3 vn single";
    do_reset(1'b1, 1'b0);
    wait_outputs(20);
    cur_req = "R5 modes changed after reset";
    vn_in = 1'b0; dual_in = 1'b1;
    wait_outputs(40);
    check(alarm == 1'b0, "R8 jittered vn", alarm, 0);

    // XOR, dual edge (R4)
    cur_req = "R4 xor dual";
    do_reset(1'b0, 1'b1);
    wait_outputs(50);
    check(alarm == 1'b0, "R8 jittered dual", alarm, 0);

    // von Neumann, dual edge: falling sample first (R4)
    cur_req = "R4 vn dual";
    do_reset(1'b1, 1'b1);
    wait_outputs(40);
    check(alarm == 1'b0, "R8 jittered vn dual", alarm, 0);

    // exactly periodic source: constant length 4 (R8), sticky (R9)
    a_mode = 1;
    cur_req = "R2 periodic";
    do_reset(1'b0, 1'b0);
    repeat (150) @(posedge samp_osc);
    #30;
    check(alarm == 1'b0, "R8 too early for alarm", alarm, 0);
    repeat (450) @(posedge samp_osc);
    #30;
    check(alarm == 1'b1, "R8 periodic alarm", alarm, 1);
    a_mode = 0;
    repeat (200) @(posedge samp_osc);
    #30;
    check(alarm == 1'b1, "R9 alarm sticky", alarm, 1);

    // stuck-low source: saturation drives the alarm (R7)
    a_mode = 2;
    cur_req = "R2 stuck";
    do_reset(1'b0, 1'b0);
    repeat (200) @(posedge samp_osc);
    #30;
    check(alarm == 1'b0, "R7 before saturation", alarm, 0);
    repeat (300) @(posedge samp_osc);
    #30;
    check(alarm == 1'b1, "R7 saturated alarm", alarm, 1);
    check(popped > 100, "R6 stuck outputs seen", popped, 101);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule